// File: doc/BRIEF.md
# Bus Master Domain Assignment Matcher

This block tags each bus transaction of one master with a domain number, a nonsecure attribute and a privileged attribute. A small table of assignment descriptors is programmed through a write port. Each descriptor carries an enable bit, a match value, a mask, a domain number, a secure attribute, a privileged attribute and a lock bit. When a transaction arrives with its per-master match input, every enabled descriptor compares that input against its match value, and the bit positions whose mask bit is one are left out of the comparison. The lowest-numbered hitting descriptor supplies the attributes, which appear registered one cycle later.

The width of the match field is a parameter from 0 to 16 bits. A width of 0 makes every enabled descriptor hit. When no enabled descriptor hits, the block reports a miss and emits a fixed default domain as a nonsecure, unprivileged access. Setting a descriptor's lock bit freezes the descriptor until reset. A write aimed at a frozen descriptor is dropped and answered with a one-cycle error pulse. A combinational read port returns any descriptor, so software and the bench can see what is stored.

Top module: `dom_assign_top`

## Requirements
- R1: After reset every descriptor reads back with all fields zero (disabled, unlocked), `outValid` and `wrErr` are 0.
- R2: A write with `wrEn`=1 to an unlocked descriptor stores all seven fields. The match and mask read back with every bit at or above MATCH_W equal to 0.
- R3: An enabled descriptor hits when `((txnMatch ^ match) & ~mask)` is zero over bits [MATCH_W-1:0]. Bits of `txnMatch` at or above MATCH_W have no effect.
- R4: An enabled descriptor whose mask is all ones over the implemented width hits every transaction.
- R5: With MATCH_W = 0 every enabled descriptor hits every transaction, and match and mask read back as 0.
- R6: A descriptor with its enable bit at 0 never hits.
- R7: When several enabled descriptors hit, the one with the lowest index supplies the outputs.
- R8: One cycle after `txnValid`=1, `outValid`=1 and, on a hit, `outDomain` is the winner's domain, `outNonsecure` is the inverse of its secure bit, `outPriv` is its privileged bit and `outMiss`=0. Without `txnValid`, `outValid` is 0 in the next cycle.
- R9: On a miss, `outDomain`=DFLT_DOM, `outNonsecure`=1, `outPriv`=0 and `outMiss`=1.
- R10: Once a descriptor is written with `wrLock`=1, later writes leave all its fields unchanged. Only reset clears the lock.
- R11: `wrErr` is 1 in exactly the cycle after a write to a locked descriptor, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Descriptor write strobe |
| wrIdx | input | IDX_W | Descriptor index to write |
| wrEnable | input | 1 | Enable bit to store |
| wrMatch | input | 16 | Match value to store |
| wrMask | input | 16 | Mask to store (1 = ignore bit) |
| wrDomain | input | 4 | Domain number to store |
| wrSecure | input | 1 | Secure attribute to store |
| wrPriv | input | 1 | Privileged attribute to store |
| wrLock | input | 1 | Lock bit to store |
| wrErr | output | 1 | One-cycle pulse after a write to a locked descriptor |
| rdIdx | input | IDX_W | Descriptor index to read |
| rdEnable | output | 1 | Stored enable bit |
| rdMatch | output | 16 | Stored match value, zero-extended |
| rdMask | output | 16 | Stored mask, zero-extended |
| rdDomain | output | 4 | Stored domain number |
| rdSecure | output | 1 | Stored secure attribute |
| rdPriv | output | 1 | Stored privileged attribute |
| rdLock | output | 1 | Stored lock bit |
| txnValid | input | 1 | Transaction present this cycle |
| txnMatch | input | 16 | Per-master match input |
| outValid | output | 1 | Registered result valid |
| outDomain | output | 4 | Assigned domain number |
| outNonsecure | output | 1 | Nonsecure attribute of the transaction |
| outPriv | output | 1 | Privileged attribute of the transaction |
| outMiss | output | 1 | No enabled descriptor hit |

## Verification
The hardest state to reach is a table that holds several overlapping enabled descriptors, some of them locked, while transactions land on exactly the bits that the masks leave out. Random match inputs almost never hit a descriptor with a sparse mask. For that reason the stimulus usually takes a stored match value, flips only bits that its mask covers, and flips bits above the implemented width. Directed sequences add the all-ones mask, a disabled descriptor that would otherwise win, a priority tie, locking with rejected rewrites, and a second instance with a zero-width match field.

// File: rtl/dom_assign_pkg.sv
package dom_assign_pkg;
  localparam int FIELD_W = 16;
  localparam int DOM_W   = 4;

  typedef struct packed {
    logic load;     // store write-port fields into the addressed descriptor
    logic capture;  // register a transaction result
  } strobe_t;
endpackage

// File: rtl/dom_assign_dp.sv
module dom_assign_dp
  import dom_assign_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int MATCH_W  = 8,
  parameter int IDX_W    = 3,
  parameter logic [DOM_W-1:0] DFLT_DOM = 4'hF
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               wrEnable,
  input  logic [FIELD_W-1:0] wrMatch,
  input  logic [FIELD_W-1:0] wrMask,
  input  logic [DOM_W-1:0]   wrDomain,
  input  logic               wrSecure,
  input  logic               wrPriv,
  input  logic               wrLock,
  output logic [NUM_DESC-1:0] lockVec,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic               rdEnable,
  output logic [FIELD_W-1:0] rdMatch,
  output logic [FIELD_W-1:0] rdMask,
  output logic [DOM_W-1:0]   rdDomain,
  output logic               rdSecure,
  output logic               rdPriv,
  output logic               rdLock,
  input  logic [FIELD_W-1:0] txnMatch,
  output logic               outValid,
  output logic [DOM_W-1:0]   outDomain,
  output logic               outNonsecure,
  output logic               outPriv,
  output logic               outMiss
);
  localparam int MW_EFF = (MATCH_W > 0) ? MATCH_W : 1;

  logic [NUM_DESC-1:0] enVec;
  logic [NUM_DESC-1:0] secVec;
  logic [NUM_DESC-1:0] privVec;
  logic [NUM_DESC-1:0] hitVec;
  logic [MW_EFF-1:0]   descMatch [NUM_DESC];
  logic [MW_EFF-1:0]   descMask  [NUM_DESC];
  logic [DOM_W-1:0]    descDom   [NUM_DESC];

  // descriptor storage and per-descriptor comparators
  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic selWr;
    assign selWr = stb.load && (wrIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enVec[i]     <= 1'b0;
        secVec[i]    <= 1'b0;
        privVec[i]   <= 1'b0;
        lockVec[i]   <= 1'b0;
        descMatch[i] <= '0;
        descMask[i]  <= '0;
        descDom[i]   <= '0;
      end else if (selWr) begin
        enVec[i]     <= wrEnable;
        secVec[i]    <= wrSecure;
        privVec[i]   <= wrPriv;
        lockVec[i]   <= wrLock;
        descMatch[i] <= (MATCH_W > 0) ? wrMatch[MW_EFF-1:0] : '0;
        descMask[i]  <= (MATCH_W > 0) ? wrMask[MW_EFF-1:0]  : '0;
        descDom[i]   <= wrDomain;
      end
    end

    if (MATCH_W == 0) begin : g_zero
      assign hitVec[i] = enVec[i];
    end else begin : g_cmp
      logic [MW_EFF-1:0] diff;
      assign diff      = (txnMatch[MW_EFF-1:0] ^ descMatch[i]) & ~descMask[i];
      assign hitVec[i] = enVec[i] && (diff == '0);
    end

    // a locked descriptor keeps every field until reset
    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      lockVec[i] |=> (lockVec[i] && $stable(descMatch[i]) && $stable(descMask[i])
                      && $stable(descDom[i]) && $stable(enVec[i]))); // R10
  end

  // lowest index wins
  logic [IDX_W-1:0] winIdx;
  logic             anyHit;
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_DESC - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  // read port
  logic rdInRange;
  assign rdInRange = (32'(rdIdx) < NUM_DESC);
  always_comb begin
    rdEnable = 1'b0;
    rdMatch  = '0;
    rdMask   = '0;
    rdDomain = '0;
    rdSecure = 1'b0;
    rdPriv   = 1'b0;
    rdLock   = 1'b0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rdInRange && rdIdx == IDX_W'(i)) begin
        rdEnable = enVec[i];
        rdDomain = descDom[i];
        rdSecure = secVec[i];
        rdPriv   = privVec[i];
        rdLock   = lockVec[i];
        if (MATCH_W > 0) begin
          rdMatch = FIELD_W'(descMatch[i]);
          rdMask  = FIELD_W'(descMask[i]);
        end
      end
    end
  end

  // registered result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outDomain    <= DFLT_DOM;
      outNonsecure <= 1'b1;
      outPriv      <= 1'b0;
      outMiss      <= 1'b0;
    end else begin
      outValid <= stb.capture;
      if (stb.capture) begin
        if (anyHit) begin
          outDomain    <= descDom[winIdx];
          outNonsecure <= ~secVec[winIdx];
          outPriv      <= privVec[winIdx];
          outMiss      <= 1'b0;
        end else begin
          outDomain    <= DFLT_DOM;
          outNonsecure <= 1'b1;
          outPriv      <= 1'b0;
          outMiss      <= 1'b1;
        end
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> outValid); // R8

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> !outValid); // R8

  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMiss) |-> (outNonsecure && !outPriv && outDomain == DFLT_DOM)); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && enVec == '0) |=> outMiss); // R6

  AST_ALL_ONES_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && enVec[0] && (&descMask[0]))
      |=> (!outMiss && outDomain == $past(descDom[0]))); // R4

  if (MATCH_W == 0) begin : g_zero_chk
    AST_ZERO_W_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (stb.capture && enVec != '0) |=> !outMiss); // R5
  end
endmodule

// File: rtl/dom_assign_ctrl.sv
module dom_assign_ctrl
  import dom_assign_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                txnValid,
  input  logic [NUM_DESC-1:0] lockVec,
  output strobe_t             stb,
  output logic                wrErr
);
  logic inRange;
  logic lockSel;

  assign inRange = (32'(wrIdx) < NUM_DESC);

  always_comb begin
    lockSel = 1'b0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (wrIdx == IDX_W'(i)) lockSel = lockVec[i];
    end
  end

  assign stb.load    = wrEn && inRange && !lockSel;
  assign stb.capture = txnValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= wrEn && inRange && lockSel;
  end

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn)); // R11

  AST_NO_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lockSel) |-> !stb.load); // R10
endmodule

// File: rtl/dom_assign_top.sv
module dom_assign_top
  import dom_assign_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int MATCH_W  = 8,
  parameter int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  parameter logic [3:0] DFLT_DOM = 4'hF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrEnable,
  input  logic [15:0]      wrMatch,
  input  logic [15:0]      wrMask,
  input  logic [3:0]       wrDomain,
  input  logic             wrSecure,
  input  logic             wrPriv,
  input  logic             wrLock,
  output logic             wrErr,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdEnable,
  output logic [15:0]      rdMatch,
  output logic [15:0]      rdMask,
  output logic [3:0]       rdDomain,
  output logic             rdSecure,
  output logic             rdPriv,
  output logic             rdLock,
  input  logic             txnValid,
  input  logic [15:0]      txnMatch,
  output logic             outValid,
  output logic [3:0]       outDomain,
  output logic             outNonsecure,
  output logic             outPriv,
  output logic             outMiss
);
  strobe_t             stb;
  logic [NUM_DESC-1:0] lockVec;

  dom_assign_ctrl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .txnValid(txnValid),
    .lockVec(lockVec), .stb(stb), .wrErr(wrErr)
  );

  dom_assign_dp #(.NUM_DESC(NUM_DESC), .MATCH_W(MATCH_W), .IDX_W(IDX_W),
                  .DFLT_DOM(DFLT_DOM)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrEnable(wrEnable),
    .wrMatch(wrMatch), .wrMask(wrMask), .wrDomain(wrDomain), .wrSecure(wrSecure),
    .wrPriv(wrPriv), .wrLock(wrLock), .lockVec(lockVec), .rdIdx(rdIdx),
    .rdEnable(rdEnable), .rdMatch(rdMatch), .rdMask(rdMask), .rdDomain(rdDomain),
    .rdSecure(rdSecure), .rdPriv(rdPriv), .rdLock(rdLock), .txnMatch(txnMatch),
    .outValid(outValid), .outDomain(outDomain), .outNonsecure(outNonsecure),
    .outPriv(outPriv), .outMiss(outMiss)
  );

  AST_ERR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> !wrErr); // R11
endmodule

// File: tb/sim_dom_assign_top.sv
module sim_dom_assign_top;
  localparam int ND = 8;
  localparam int MW = 8;
  localparam logic [3:0] DFLT = 4'hF;
  localparam logic [15:0] WMASK = 16'h00FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic wrEn = 0, wrEnable = 0, wrSecure = 0, wrPriv = 0, wrLock = 0;
  logic [2:0] wrIdx = 0, rdIdx = 0;
  logic [15:0] wrMatch = 0, wrMask = 0, txnMatch = 0;
  logic [3:0] wrDomain = 0;
  logic txnValid = 0;
  logic wrErr, rdEnable, rdSecure, rdPriv, rdLock;
  logic [15:0] rdMatch, rdMask;
  logic [3:0] rdDomain, outDomain;
  logic outValid, outNonsecure, outPriv, outMiss;

  dom_assign_top #(.NUM_DESC(ND), .MATCH_W(MW), .DFLT_DOM(DFLT)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrEnable(wrEnable),
    .wrMatch(wrMatch), .wrMask(wrMask), .wrDomain(wrDomain), .wrSecure(wrSecure),
    .wrPriv(wrPriv), .wrLock(wrLock), .wrErr(wrErr), .rdIdx(rdIdx),
    .rdEnable(rdEnable), .rdMatch(rdMatch), .rdMask(rdMask), .rdDomain(rdDomain),
    .rdSecure(rdSecure), .rdPriv(rdPriv), .rdLock(rdLock), .txnValid(txnValid),
    .txnMatch(txnMatch), .outValid(outValid), .outDomain(outDomain),
    .outNonsecure(outNonsecure), .outPriv(outPriv), .outMiss(outMiss)
  );

  // zero-width instance
  logic zWrEn = 0, zTxnValid = 0;
  logic [15:0] zTxnMatch = 0;
  logic zWrErr, zRdEnable, zRdSecure, zRdPriv, zRdLock;
  logic [15:0] zRdMatch, zRdMask;
  logic [3:0] zRdDomain, zOutDomain;
  logic zOutValid, zOutNonsecure, zOutPriv, zOutMiss;

  dom_assign_top #(.NUM_DESC(2), .MATCH_W(0), .DFLT_DOM(4'h3)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(zWrEn), .wrIdx(1'b0), .wrEnable(1'b1),
    .wrMatch(16'hFFFF), .wrMask(16'h0000), .wrDomain(4'h9), .wrSecure(1'b1),
    .wrPriv(1'b1), .wrLock(1'b0), .wrErr(zWrErr), .rdIdx(1'b0),
    .rdEnable(zRdEnable), .rdMatch(zRdMatch), .rdMask(zRdMask), .rdDomain(zRdDomain),
    .rdSecure(zRdSecure), .rdPriv(zRdPriv), .rdLock(zRdLock), .txnValid(zTxnValid),
    .txnMatch(zTxnMatch), .outValid(zOutValid), .outDomain(zOutDomain),
    .outNonsecure(zOutNonsecure), .outPriv(zOutPriv), .outMiss(zOutMiss)
  );

  // bench model of the descriptor table
  logic        mEn [ND];
  logic [15:0] mMatch [ND];
  logic [15:0] mMask [ND];
  logic [3:0]  mDom [ND];
  logic        mSec [ND];
  logic        mPriv [ND];
  logic        mLock [ND];

  task automatic clearModel();
    for (int i = 0; i < ND; i++) begin
      mEn[i] = 0; mMatch[i] = 0; mMask[i] = 0; mDom[i] = 0;
      mSec[i] = 0; mPriv[i] = 0; mLock[i] = 0;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected result: {miss, nonsecure, priv, domain}
  function automatic logic [6:0] expect_out(input logic [15:0] t);
    for (int i = 0; i < ND; i++) begin
      if (mEn[i] && (((t ^ mMatch[i]) & ~mMask[i] & WMASK) == 16'h0))
        return {1'b0, ~mSec[i], mPriv[i], mDom[i]};
    end
    return {1'b1, 1'b1, 1'b0, DFLT};
  endfunction

  task automatic doWrite(input int idx, input bit en, input logic [15:0] m,
                         input logic [15:0] mk, input logic [3:0] d,
                         input bit s, input bit p, input bit lk);
    bit wasLocked;
    wasLocked = mLock[idx];
    @(negedge clk);
    wrEn = 1; wrIdx = 3'(idx); wrEnable = en; wrMatch = m; wrMask = mk;
    wrDomain = d; wrSecure = s; wrPriv = p; wrLock = lk;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
    check(wrErr == wasLocked, "R11 error pulse", 32'(wrErr), 32'(wasLocked));
    if (!wasLocked) begin
      mEn[idx] = en; mMatch[idx] = m & WMASK; mMask[idx] = mk & WMASK;
      mDom[idx] = d; mSec[idx] = s; mPriv[idx] = p; mLock[idx] = lk;
    end
    @(posedge clk);
    #1;
    check(wrErr == 1'b0, "R11 single cycle", 32'(wrErr), 32'h0);
  endtask

  task automatic readCheck(input int idx, input string req);
    @(negedge clk);
    rdIdx = 3'(idx);
    #1;
    check({rdEnable, rdMatch, rdMask, rdDomain, rdSecure, rdPriv, rdLock} ==
          {mEn[idx], mMatch[idx], mMask[idx], mDom[idx], mSec[idx], mPriv[idx], mLock[idx]},
          req, {rdLock, rdEnable, rdDomain, rdMask[7:0], rdMatch[7:0]},
          {mLock[idx], mEn[idx], mDom[idx], mMask[idx][7:0], mMatch[idx][7:0]});
  endtask

  task automatic doTxn(input logic [15:0] t, input string req);
    logic [6:0] e;
    e = expect_out(t);
    @(negedge clk);
    txnValid = 1; txnMatch = t;
    @(posedge clk);
    @(negedge clk);
    txnValid = 0;
    check(outValid && {outMiss, outNonsecure, outPriv, outDomain} == e, req,
          {outValid, outMiss, outNonsecure, outPriv, outDomain}, {1'b1, e});
    @(posedge clk);
    #1;
    check(!outValid, "R8 valid drops", 32'(outValid), 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clearModel();
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && !wrErr, "R1 reset outputs", {outValid, wrErr}, 0);
    @(negedge clk) rstN = 1;
    for (int i = 0; i < ND; i++) readCheck(i, "R1 reset descriptor");

    // R2 write, readback, upper bits zero
    doWrite(3, 1, 16'hABCD, 16'h1230, 4'h7, 1, 0, 0);
    readCheck(3, "R2 readback truncated");

    // R3 masked compare: mask 0x30 ignores bits 5:4; upper txn bits ignored
    doTxn(16'h00CD, "R3 exact");
    doTxn(16'hFFFD, "R3 masked bits and upper bits ignored");
    doTxn(16'h00CC, "R9 miss on compared bit");

    // R6 disabled descriptor at lower index with same match
    doWrite(1, 0, 16'h00CD, 16'h0000, 4'h2, 0, 1, 0);
    doTxn(16'h00CD, "R6 disabled does not win");

    // R7 priority: enable index 1, it now wins over 3
    doWrite(1, 1, 16'h00CD, 16'h0000, 4'h2, 0, 1, 0);
    doTxn(16'h00CD, "R7 lowest index wins");

    // R4 all-ones mask at index 0 catches everything
    doWrite(0, 1, 16'h0055, 16'hFFFF, 4'hA, 1, 1, 0);
    doTxn(16'h1234, "R4 all-ones mask");
    doTxn(16'h00CD, "R4 all-ones beats others");
    doWrite(0, 0, 16'h0, 16'h0, 4'h0, 0, 0, 0);

    // R10 lock and rejected rewrite
    doWrite(5, 1, 16'h0042, 16'h0000, 4'h5, 0, 0, 1);
    doWrite(5, 0, 16'h0099, 16'h00FF, 4'hC, 1, 1, 0);
    readCheck(5, "R10 locked fields unchanged");
    doTxn(16'h0042, "R10 locked descriptor still used");

    // R5 zero-width instance
    @(negedge clk) zWrEn = 1;
    @(negedge clk) zWrEn = 0; zTxnValid = 1; zTxnMatch = 16'h1357;
    @(negedge clk) zTxnValid = 0;
    check(zOutValid && !zOutMiss && zOutDomain == 4'h9 && !zOutNonsecure && zOutPriv,
          "R5 zero width hits", {zOutValid, zOutMiss, zOutDomain}, {1'b1, 1'b0, 4'h9});
    check(zRdMatch == 0 && zRdMask == 0 && zRdEnable, "R5 zero width readback",
          {zRdMatch, zRdMask}, 0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        doWrite(int'($urandom_range(0, ND - 1)), ($urandom_range(0, 3) != 0),
                16'($urandom), 16'($urandom & $urandom & $urandom),
                4'($urandom), 1'($urandom), 1'($urandom),
                ($urandom_range(0, 29) == 0));
      end else if (op == 3) begin
        readCheck(int'($urandom_range(0, ND - 1)), "R2 random readback");
      end else begin
        logic [15:0] t;
        if ($urandom_range(0, 1) == 1) begin
          int k;
          k = int'($urandom_range(0, ND - 1));
          t = (mMatch[k] & ~mMask[k]) | (16'($urandom) & (mMask[k] | ~WMASK));
        end else begin
          t = 16'($urandom);
        end
        doTxn(t, "R3 R7 R8 R9 random transaction");
      end
    end

    // R10: reset clears locks, descriptor writable again
    @(negedge clk) rstN = 0;
    clearModel();
    @(negedge clk) rstN = 1;
    readCheck(5, "R10 reset clears lock");
    doWrite(5, 1, 16'h0011, 16'h0000, 4'h4, 1, 0, 0);
    readCheck(5, "R10 writable after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule